// File: doc/BRIEF.md
# Address-Masked Eight-Pin GPIO Controller

This block is an eight-pin general-purpose I/O controller on a simple APB-style bus with no wait states. Its data register sits behind a window of 256 word addresses. The word-address bits of each access act as a per-pin mask, so software can set or clear any group of pins with one bus write and no read-modify-write.

A direction register marks each pin as an output or an input. Outputs leave on an output bus that comes with a matching output-enable bus. Input levels pass through a two-stage synchroniser before they can be read back.

A design that needs more than eight pins places several instances side by side.

Top module: `gpio_mask_port`

## Requirements
- R1: An address in 0x000..0x3FC selects the data register. The mask bit for pin i is paddr[i+2], so the single-pin address of pin i is 1 << (i+2), and 0x3FC reaches all eight pins.
- R2: A data write loads pwdata[i] into data bit i for every pin whose mask bit is 1.
- R3: A data write leaves unchanged every data bit whose mask bit is 0. Writing 0 to the single-pin address of pin i drives only pin i low.
- R4: A data read returns 0 in every bit whose mask bit is 0, whatever the state of that pin.
- R5: In a data read, a pin with mask bit 1 returns its last written data bit if it is an output, or its synchronised gpin level if it is an input.
- R6: A change on gpin appears in reads after exactly two rising clock edges: it is not visible after one edge and is visible after two.
- R7: The direction register sits at byte address 0x400, with bit i = 1 making pin i an output. It reads back the value last written to it.
- R8: gpoe equals the direction register. gpout[i] equals data bit i where pin i is an output and is 0 where pin i is an input.
- R9: After reset the data register, the direction register and the synchroniser are all 0, so every pin is an input and gpout and gpoe are 0.
- R10: A register changes only on a clock edge where psel, penable and pwrite are all 1 and the address decodes. A setup phase alone, or a write to any other address (for example 0x404 or 0x800), changes nothing.
- R11: prdata is 0 when psel is 0, when pwrite is 1, or when the address is neither in the data window nor 0x400.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Block select |
| penable | input | 1 | Access phase of a transfer |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address; bits 9:2 carry the pin mask in the data window |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, valid combinationally during a read |
| gpin | input | 8 | Pin input levels, asynchronous to pclk |
| gpout | output | 8 | Output levels, gated by direction |
| gpoe | output | 8 | Per-pin output enable |

## Verification
With all pins set as outputs, the bench sweeps all 256 write masks, each with its own data pattern. This separates the pins that must take the new bit from the pins that must hold. It then sweeps all 256 read masks over a fixed value, which separates the pins that are returned from the pins that read as zero. A mixed direction pattern with unlike input and output values shows whether each pin reads back from the right source and whether gpout is gated. Single-pin clears with all pins high isolate each pin's address. A gpin step held under a continuous read pins the synchroniser latency to exactly two edges, and setup-only and undecoded accesses show whether stray writes are ignored.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PINS   = 8;
  localparam int ADDR_W = 12;

  typedef struct packed {
    logic            dataWr;
    logic            dirWr;
    logic            dataRd;
    logic            dirRd;
    logic [PINS-1:0] mask;
  } gpio_strobe_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int NPINS = PINS,
  parameter int AW    = ADDR_W
) (
  input  logic         psel,
  input  logic         penable,
  input  logic         pwrite,
  input  logic [AW-1:0] paddr,
  output gpio_strobe_t st
);
  localparam int MASK_LSB = 2;
  localparam int MASK_MSB = NPINS + MASK_LSB - 1;
  localparam logic [AW-1:0] DIR_ADDR = AW'(1) << (NPINS + MASK_LSB);

  logic inWindow;
  logic atDir;
  logic access;

  // The data window is every address whose bits above the mask are zero.
  assign inWindow = (paddr[AW-1:MASK_MSB+1] == '0) && (paddr[MASK_LSB-1:0] == '0);
  assign atDir    = (paddr == DIR_ADDR);
  assign access   = psel && penable;

  always_comb begin
    st.dataWr = access && pwrite && inWindow;
    st.dirWr  = access && pwrite && atDir;
    st.dataRd = psel && !pwrite && inWindow;
    st.dirRd  = psel && !pwrite && atDir;
    st.mask   = paddr[MASK_MSB:MASK_LSB];
  end
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int NPINS = PINS
) (
  input  logic             clk,
  input  logic             rstN,
  input  gpio_strobe_t     st,
  input  logic [NPINS-1:0] wdata,
  input  logic [NPINS-1:0] gpin,
  output logic [NPINS-1:0] prdata,
  output logic [NPINS-1:0] gpout,
  output logic [NPINS-1:0] gpoe
);
  logic [NPINS-1:0] dataReg;
  logic [NPINS-1:0] dirReg;
  logic [NPINS-1:0] syncA;
  logic [NPINS-1:0] syncB;
  logic [NPINS-1:0] pinView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      dirReg  <= '0;
      syncA   <= '0;
      syncB   <= '0;
    end else begin
      syncA <= gpin;
      syncB <= syncA;
      if (st.dataWr) dataReg <= (dataReg & ~st.mask) | (wdata & st.mask);
      if (st.dirWr)  dirReg  <= wdata;
    end
  end

  // Per-pin source selection: output pins show the stored bit, input pins the synced level.
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign pinView[i] = dirReg[i] ? dataReg[i] : syncB[i];
    assign gpout[i]   = dataReg[i] & dirReg[i];
  end

  assign gpoe = dirReg;

  always_comb begin
    if (st.dataRd)     prdata = pinView & st.mask;
    else if (st.dirRd) prdata = dirReg;
    else               prdata = '0;
  end

  p_masked_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    st.dataWr |=> ((dataReg & $past(st.mask)) == ($past(wdata) & $past(st.mask))));

  p_unmasked_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    st.dataWr |=> ((dataReg & ~$past(st.mask)) == ($past(dataReg) & ~$past(st.mask))));

  p_idle_data_r10: assert property (@(posedge clk) disable iff (!rstN)
    !st.dataWr |=> $stable(dataReg));

  p_idle_dir_r7: assert property (@(posedge clk) disable iff (!rstN)
    !st.dirWr |=> $stable(dirReg));

  p_read_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    st.dataRd |-> ((prdata & ~st.mask) == '0));

  p_out_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    (gpout & ~gpoe) == '0);
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_pkg::*;
(
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [PINS-1:0]   pwdata,
  output logic [PINS-1:0]   prdata,
  input  logic [PINS-1:0]   gpin,
  output logic [PINS-1:0]   gpout,
  output logic [PINS-1:0]   gpoe
);
  gpio_strobe_t st;

  gpio_ctrl #(.NPINS(PINS), .AW(ADDR_W)) u_ctrl (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .st(st)
  );

  gpio_datapath #(.NPINS(PINS)) u_dp (
    .clk(pclk), .rstN(presetn), .st(st), .wdata(pwdata), .gpin(gpin),
    .prdata(prdata), .gpout(gpout), .gpoe(gpoe)
  );
endmodule

// File: tb/sim_gpio_mask_port.sv
`timescale 1ns/1ps
module sim_gpio_mask_port;
  logic        pclk = 0;
  logic        presetn = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [7:0]  pwdata = '0;
  logic [7:0]  prdata;
  logic [7:0]  gpin = '0;
  logic [7:0]  gpout, gpoe;

  int checks = 0;
  int errors = 0;
  logic [7:0] expData = '0;
  logic [7:0] expDir  = '0;
  logic [7:0] rd;

  always #10 pclk = ~pclk;

  gpio_mask_port u0 (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .gpin(gpin), .gpout(gpout), .gpoe(gpoe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [7:0] d);
    @(negedge pclk);
    psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1;
    @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [7:0] d);
    @(negedge pclk);
    psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge pclk);
    penable = 1;
    #2 d = prdata;
    psel = 0; penable = 0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge pclk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge pclk);
    // R9: reset state
    check("R9 gpout", gpout, 8'h00);
    check("R9 gpoe", gpoe, 8'h00);
    check("R11 idle prdata", prdata, 8'h00);
    presetn = 1;
    busRead(12'h400, rd); check("R9 dir", rd, 8'h00);
    busRead(12'h3FC, rd); check("R9 data", rd, 8'h00);

    // R7: all outputs, direction read-back
    busWrite(12'h400, 8'hFF); expDir = 8'hFF;
    busRead(12'h400, rd); check("R7 dir readback", rd, 8'hFF);
    check("R8 gpoe", gpoe, 8'hFF);

    // R1 R2 R3: sweep all write masks
    for (int m = 0; m < 256; m++) begin
      logic [7:0] d;
      d = 8'((m * 37 + 5) ^ (m >> 1));
      busWrite(12'(m << 2), d);
      expData = (expData & ~8'(m)) | (d & 8'(m));
      busRead(12'h3FC, rd); check("R2 R3 write mask sweep", rd, expData);
      check("R8 gpout", gpout, expData);
    end

    // R4 R5: sweep all read masks
    busWrite(12'h3FC, 8'hC6); expData = 8'hC6;
    for (int m = 0; m < 256; m++) begin
      busRead(12'(m << 2), rd); check("R4 read mask sweep", rd, expData & 8'(m));
    end

    // R3 R1: single-pin clear from all ones
    for (int i = 0; i < 8; i++) begin
      busWrite(12'h3FC, 8'hFF);
      busWrite(12'(1 << (i + 2)), 8'h00);
      check("R3 single pin clear", gpout, ~(8'(1) << i));
    end

    // R5 R8: mixed directions
    busWrite(12'h3FC, 8'hA5);
    busWrite(12'h400, 8'h0F);
    gpin = 8'h3C;
    repeat (3) @(negedge pclk);
    busRead(12'h3FC, rd); check("R5 mixed readback", rd, 8'h35);
    check("R8 mixed gpout", gpout, 8'h05);
    check("R8 mixed gpoe", gpoe, 8'h0F);
    busRead(12'h400, rd); check("R7 dir readback mixed", rd, 8'h0F);

    // R6: synchroniser latency under a held read, all inputs
    busWrite(12'h400, 8'h00);
    gpin = 8'h00;
    repeat (3) @(negedge pclk);
    psel = 1; penable = 1; pwrite = 0; paddr = 12'h3FC;
    gpin = 8'h5A;
    @(negedge pclk); check("R6 after one edge", prdata, 8'h00);
    @(negedge pclk); check("R6 after two edges", prdata, 8'h5A);
    psel = 0; penable = 0;

    // R10: setup-only write and undecoded writes
    busWrite(12'h400, 8'hFF);
    busWrite(12'h3FC, 8'h33);
    @(negedge pclk);
    psel = 1; pwrite = 1; penable = 0; paddr = 12'h3FC; pwdata = 8'hCC;
    @(negedge pclk);
    psel = 0; pwrite = 0;
    check("R10 setup-only write", gpout, 8'h33);
    busWrite(12'h404, 8'h00);
    busWrite(12'h800, 8'h00);
    check("R10 undecoded write data", gpout, 8'h33);
    busRead(12'h400, rd); check("R10 undecoded write dir", rd, 8'hFF);

    // R11: undecoded read and write-phase prdata
    busRead(12'h800, rd); check("R11 undecoded read", rd, 8'h00);
    busRead(12'h402, rd); check("R11 unaligned read", rd, 8'h00);
    @(negedge pclk);
    psel = 1; pwrite = 1; penable = 1; paddr = 12'h3FC; pwdata = 8'h33;
    #2 check("R11 prdata during write", prdata, 8'h00);
    @(negedge pclk); psel = 0; pwrite = 0; penable = 0;

    summary();
    $finish;
  end
endmodule